// File: doc/BRIEF.md
# Serial Audio Transmitter with Clock Generator

This block drives a stereo serial audio link as the clock master. From a master clock running at 256 times the sample rate it derives a bit clock and a frame clock, and it shifts one left/right sample pair per frame onto a single data line. It supports three framings: left-justified, right-justified and I2S. Each can carry 16-, 18- or 20-bit words. A 32x bit-clock ratio is available only in the 16-bit left-justified case.

A producer offers a parallel sample pair with `valid_i`. The block accepts it in the last master-clock cycle of each frame, which it marks with `ready_o`. If nothing is offered, the previous pair is sent again. Framing, word length and ratio are sampled at the same frame boundary, so a frame is never cut short by a mode change.

Top module: `aud_ser_tx`

## Requirements
- R1: For the first 256 master-clock cycles after reset release, `bclk_o`, `lrclk_o` and `sdata_o` stay low. The first frame starts on the next cycle. Each frame is 256 master clocks long.
- R2: By default `bclk_o` is the master clock divided by 4, giving 64 bit slots per frame. When framing is left-justified, the word is 16 bits and `ratio64_i` is 0, it is divided by 8 instead, giving 32 slots. In both cases the bit clock is low in the first half of each slot.
- R3: `lrclk_o` is the master clock divided by 256. The left channel occupies the first half of each frame. During that half, `lrclk_o` is high for left- and right-justified framing and low for I2S.
- R4: The `wlen_i` field selects the word length: 00 = 16 bits, 01 = 18 bits, 10 = 20 bits. The `fmt_i` field selects the framing: 00 = left-justified, 01 = right-justified, 10 = I2S. In either field, code 11 behaves as 00.
- R5: Data is sent MSB first and changes only on a falling edge of `bclk_o`. The MSB sits in the first slot of each half for left-justified framing and in the second slot for I2S. For right-justified framing the LSB sits in the last slot of each half. All other slots are driven low.
- R6: Samples are MSB-aligned in the 20-bit inputs. A W-bit word is taken from bits [19:20-W].
- R7: `ready_o` is high for exactly the last master-clock cycle of every frame, and also before the first frame. When `valid_i` is high in that cycle, both samples are used for the next frame. Otherwise the previous pair repeats. The pair is zero after reset.
- R8: `fmt_i`, `wlen_i` and `ratio64_i` are sampled only in that same last cycle. Changing them at any other time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing select |
| wlen_i | input | 2 | Word length select |
| ratio64_i | input | 1 | 1 forces the 64x bit clock in 16-bit left-justified framing |
| left_i | input | 20 | Left sample, MSB-aligned |
| right_i | input | 20 | Right sample, MSB-aligned |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Last cycle of frame; pair and mode are taken |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |

## Verification
All three outputs are registered from the next value of a single phase counter. After the k-th master-clock edge following reset release, they show phase k mod 256. They are idle while k is below 256. A pair or mode accepted at the edge that closes phase 255 therefore governs the outputs from phase 0 onward, with no extra latency. The bench counts edges itself, samples every output at the falling master-clock edge, and computes the expected bit-clock, frame-clock and data levels from that count. It sweeps all 32 combinations of the mode inputs, including reserved codes. Mode and samples are changed mid-frame and again with junk values to show they take effect only at the frame boundary.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wlen;
    logic       ratio64;
  } tx_cfg_t;

  function automatic int word_bits(logic [1:0] wlen);
    case (wlen)
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_timer.sv
module aud_tx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic             active_q_o,
  output logic             active_n_o,
  output logic             frame_end_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    frame_end_o = &cnt_q;
    cnt_n_o     = cnt_q + 1'b1;
    active_n_o  = active_q_o | frame_end_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      active_q_o <= 1'b0;
    end else begin
      cnt_q      <= cnt_n_o;
      active_q_o <= active_n_o;
    end
  end
endmodule

// File: rtl/aud_tx_latch.sv
module aud_tx_latch
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                valid_i,
  input  tx_cfg_t             cfg_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output tx_cfg_t             cfg_q_o,
  output tx_cfg_t             cfg_n_o,
  output logic [SAMPLE_W-1:0] left_n_o,
  output logic [SAMPLE_W-1:0] right_n_o
);
  logic [SAMPLE_W-1:0] left_q, right_q;
  logic                take;

  always_comb begin
    take      = load_i & valid_i;
    cfg_n_o   = load_i ? cfg_i : cfg_q_o;
    left_n_o  = take ? left_i : left_q;
    right_n_o = take ? right_i : right_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q_o <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      cfg_q_o <= cfg_n_o;
      left_q  <= left_n_o;
      right_q <= right_n_o;
    end
  end
endmodule

// File: rtl/aud_tx_enc.sv
module aud_tx_enc
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int CNT_W    = 8
) (
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                active_i,
  input  tx_cfg_t             cfg_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o
);
  localparam int LG_F       = CNT_W - 6;  // master clocks per fast slot, log2
  localparam int HALF_SLOTS = 32;
  localparam int IDX_W      = $clog2(SAMPLE_W);

  fmt_e                fmt_eff;
  int                  wl, s, hs, pos;
  logic                slow, half, bit_v;
  logic [SAMPLE_W-1:0] word;
  logic [IDX_W-1:0]    idx;

  always_comb begin
    fmt_eff = (cfg_i.fmt == FMT_RSV) ? FMT_LJ : cfg_i.fmt;
    wl      = word_bits(cfg_i.wlen);
    slow    = (fmt_eff == FMT_LJ) && (wl == 16) && !cfg_i.ratio64;
    half    = cnt_i[CNT_W-1];
    s       = slow ? int'(cnt_i[CNT_W-2:LG_F+1]) : int'(cnt_i[CNT_W-2:LG_F]);
    hs      = slow ? HALF_SLOTS / 2 : HALF_SLOTS;
    word    = half ? right_i : left_i;
    unique case (fmt_eff)
      FMT_RJ:  pos = s - (hs - wl);
      FMT_I2S: pos = s - 1;
      default: pos = s;
    endcase
    idx   = '0;
    bit_v = 1'b0;
    if (pos >= 0 && pos < wl) begin
      idx   = IDX_W'(SAMPLE_W - 1 - pos);
      bit_v = word[idx];
    end
    bclk_o  = active_i & (slow ? cnt_i[LG_F] : cnt_i[LG_F-1]);
    lrclk_o = active_i & ((fmt_eff == FMT_I2S) ? half : ~half);
    sdata_o = active_i & bit_v;
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int MCLK_RATIO = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic                ratio64_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                sdata_o
);
  localparam int CNT_W = $clog2(MCLK_RATIO);

  logic [CNT_W-1:0]    cnt_n;
  logic                active_q, active_n, frame_end;
  tx_cfg_t             cfg_in, cfg_q, cfg_n;
  logic [SAMPLE_W-1:0] left_n, right_n;
  logic                bclk_d, lrclk_d, sdata_d;
  logic                bclk_q, lrclk_q, sdata_q;

  assign cfg_in = '{fmt: fmt_e'(fmt_i), wlen: wlen_i, ratio64: ratio64_i};

  aud_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .cnt_n_o    (cnt_n),
    .active_q_o (active_q),
    .active_n_o (active_n),
    .frame_end_o(frame_end)
  );

  aud_tx_latch #(.SAMPLE_W(SAMPLE_W)) u_latch (
    .clk_i, .rst_ni,
    .load_i   (frame_end),
    .valid_i  (valid_i),
    .cfg_i    (cfg_in),
    .left_i   (left_i),
    .right_i  (right_i),
    .cfg_q_o  (cfg_q),
    .cfg_n_o  (cfg_n),
    .left_n_o (left_n),
    .right_n_o(right_n)
  );

  // encode next state so outputs leave flops aligned with the counter
  aud_tx_enc #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_enc (
    .cnt_i   (cnt_n),
    .active_i(active_n),
    .cfg_i   (cfg_n),
    .left_i  (left_n),
    .right_i (right_n),
    .bclk_o  (bclk_d),
    .lrclk_o (lrclk_d),
    .sdata_o (sdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      bclk_q  <= bclk_d;
      lrclk_q <= lrclk_d;
      sdata_q <= sdata_d;
    end
  end

  assign ready_o = frame_end;
  assign bclk_o  = bclk_q;
  assign lrclk_o = lrclk_q;
  assign sdata_o = sdata_q;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk
  import aud_tx_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    ready_o,
  input logic    bclk_o,
  input logic    lrclk_o,
  input logic    sdata_o,
  input logic    active_i,
  input tx_cfg_t cfg_i
);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!bclk_o && !lrclk_o && !sdata_o));

  a_r5_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !$stable(sdata_o)) |-> $fell(bclk_o));

  a_r3_lr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !$stable(lrclk_o)) |-> $fell(bclk_o));

  a_r7_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r8_cfg_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ready_o) |-> $stable(cfg_i));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_o (ready_o),
  .bclk_o  (bclk_o),
  .lrclk_o (lrclk_o),
  .sdata_o (sdata_o),
  .active_i(active_q),
  .cfg_i   (cfg_q)
);

// File: tb/aud_ser_tx_tb_top.sv
`timescale 1ns/1ps
module aud_ser_tx_tb_top;
  localparam int FRAMES = 34;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt_i = '0, wlen_i = '0;
  logic        ratio64_i = 1'b0, valid_i = 1'b0;
  logic [19:0] left_i = '0, right_i = '0;
  logic        ready_o, bclk_o, lrclk_o, sdata_o;

  int  vectors = 0, errors = 0;
  bit  done = 0;

  // model state: config and samples governing the current frame
  logic [1:0]  m_fmt = '0, m_wlen = '0, p_fmt = '0, p_wlen = '0;
  logic        m_ratio = 1'b0, p_ratio = 1'b0, p_valid = 1'b0;
  logic [19:0] m_l = '0, m_r = '0, p_l = '0, p_r = '0;

  always #5 clk_i = ~clk_i;

  aud_ser_tx dut_i (
    .clk_i, .rst_ni, .fmt_i, .wlen_i, .ratio64_i, .left_i, .right_i,
    .valid_i, .ready_o, .bclk_o, .lrclk_o, .sdata_o
  );

  task automatic check_bit(string req, string what, logic act, logic exp, int k);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at k=%0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  task automatic check_cycle(int k);
    int  c, f, wl, s, hs, pos;
    bit  s32, half;
    logic eb, el, ed, er;
    logic [19:0] w;
    c  = k % 256;
    er = (c == 255);
    eb = 0; el = 0; ed = 0;
    if (k >= 256) begin
      half = (c >= 128);
      f    = (m_fmt == 2'd3) ? 0 : int'(m_fmt);                  // R4
      wl   = (m_wlen == 2'd1) ? 18 : (m_wlen == 2'd2) ? 20 : 16;  // R4
      s32  = (f == 0) && (wl == 16) && !m_ratio;
      eb   = s32 ? logic'((c / 4) % 2) : logic'((c / 2) % 2);
      el   = (f == 2) ? half : !half;
      s    = s32 ? (c % 128) / 8 : (c % 128) / 4;
      hs   = s32 ? 16 : 32;
      w    = half ? m_r : m_l;
      pos  = (f == 0) ? s : (f == 2) ? s - 1 : s - (hs - wl);
      if (pos >= 0 && pos < wl) ed = w[19 - pos];                // R6
    end
    vectors++;
    if (k < 256) begin
      check_bit("R1", "bclk idle", bclk_o, eb, k);
      check_bit("R1", "lrclk idle", lrclk_o, el, k);
      check_bit("R1", "sdata idle", sdata_o, ed, k);
    end else begin
      check_bit("R2", "bclk", bclk_o, eb, k);
      check_bit("R3", "lrclk", lrclk_o, el, k);
      check_bit("R5", "sdata", sdata_o, ed, k);
    end
    check_bit("R7", "ready", ready_o, er, k);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    check_bit("R1", "reset bclk", bclk_o, 1'b0, -1);
    check_bit("R7", "reset ready", ready_o, 1'b0, -1);
    vectors++;
    rst_ni = 1'b1;
    k = 0;
    while (k < FRAMES * 256) begin
      check_cycle(k);
      if (k % 256 == 255) begin
        // frame boundary: R7 R8 take pending values
        m_fmt = p_fmt; m_wlen = p_wlen; m_ratio = p_ratio;
        if (p_valid) begin m_l = p_l; m_r = p_r; end
      end
      if (k % 256 == 37) begin
        int g, cf;
        g  = k / 256;
        cf = g % 32;
        p_fmt   = 2'(cf >> 3);
        p_wlen  = 2'(cf >> 1);
        p_ratio = 1'(cf);
        p_valid = (g % 5 != 2);
        p_l     = 20'(g * 239_047 + 127_203);
        p_r     = ~p_l ^ 20'(g << 3);
        fmt_i = p_fmt; wlen_i = p_wlen; ratio64_i = p_ratio;
        left_i = p_l; right_i = p_r; valid_i = p_valid;
      end
      if (k % 256 == 120) begin
        // R8: mid-frame junk must not disturb the current frame
        fmt_i = ~p_fmt; wlen_i = ~p_wlen; ratio64_i = ~p_ratio;
        left_i = 20'hA5A5A; right_i = 20'h5A5A5; valid_i = 1'b1;
      end
      if (k % 256 == 180) begin
        fmt_i = p_fmt; wlen_i = p_wlen; ratio64_i = p_ratio;
        left_i = p_l; right_i = p_r; valid_i = p_valid;
      end
      @(posedge clk_i);
      @(negedge clk_i);
      k++;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule